// File: doc/BRIEF.md
# Packetized Data Port Handshake

This block moves a transfer between a host register interface and a byte-wide flash-side stream as a sequence of equal-sized packets. The host programs a packet size and a packet count, then starts the transfer in one of two directions. In the read direction, flash bytes are collected into a one-packet buffer. The host is told through a read-ready event that a whole packet is waiting, and it empties the buffer as 32-bit words through one data port register. In the write direction, a write-ready event invites the host to fill the buffer with words. The block then plays the packet out as bytes.

Every packet occupies a whole number of 32-bit words on both sides: the byte count per packet is the programmed size rounded up to a multiple of four. Events are latched into a status register only when their status-enable bit is set, and they are cleared by writing ones. An interrupt line is raised for any latched event whose signal-enable bit is set.

Both flash-side byte streams use valid/ready. A byte moves only in a cycle where valid and ready are both high. The block holds `in_ready` low whenever its buffer is full or idle. Once it raises `out_valid`, it keeps that signal and `out_data` unchanged until the sink takes the byte with `out_ready`.

Top module: `ppx_xfer`

## Requirements
- R1: Host word addresses are 0 packet configuration, 1 start, 2 event status, 3 status enable, 4 interrupt enable, 5 data port. In the configuration register, bits 10:0 hold the packet size in bytes (1 to 2047) and bits 23:12 hold the packet count; all other bits read as zero. Every register reads zero after reset.
- R2: Writing address 1 with bit 0 set starts a transfer. Bit 1 selects the direction (1 = flash to host, 0 = host to flash). A start also restarts the packet, byte and word counters, even in the middle of a transfer.
- R3: A start with a packet size of zero or a packet count of zero moves no bytes and raises the transfer-complete event at once.
- R4: Each packet moves exactly the packet size rounded up to a multiple of four bytes on the flash-side stream, and exactly that many bytes divided by four data port words.
- R5: Word packing is little-endian: stream byte 4k+j of a packet sits in bits 8j+7:8j of data port word k.
- R6: In the read direction, the read-ready event (status bit 1) is raised when the last byte of a packet is accepted. `in_ready` then stays low until the host has read every word of that packet.
- R7: In the write direction, the write-ready event (status bit 0) is raised at the start and after each packet except the last has been fully sent. Data port writes at any other time are ignored.
- R8: The transfer-complete event (status bit 2) is raised once, on the last word read (read direction) or the last byte sent (write direction) of the final packet.
- R9: A data port read while no packet is waiting for the host returns zero and consumes nothing.
- R10: A status bit is set only by its event while its status-enable bit is set, and it is cleared by writing a one to it. If an event and a clear hit the same bit in the same cycle, the event wins.
- R11: `irq` is high exactly when some status bit and the matching interrupt-enable bit are both set.
- R12: While `out_valid` is high and `out_ready` low, `out_valid` and `out_data` hold in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host register write strobe |
| reg_rd | input | 1 | Host register read strobe (consumes a data port word) |
| reg_addr | input | 3 | Host register word address |
| reg_wdata | input | 32 | Host write data |
| reg_rdata | output | 32 | Host read data for `reg_addr`, combinational |
| in_valid | input | 1 | Flash-to-block byte valid |
| in_ready | output | 1 | Block can take a flash byte |
| in_data | input | 8 | Flash-to-block byte |
| out_valid | output | 1 | Block-to-flash byte valid |
| out_ready | input | 1 | Flash side takes the byte |
| out_data | output | 8 | Block-to-flash byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench sweeps every packet size from 1 to 9 against one to three packets in both directions, and adds the 2047-byte size. The sweep catches a design that forgets the round-up, because it would move too few bytes or words on sizes that are not a multiple of four; it also catches a design that overflows its counter at 2048 bytes or swaps byte lanes. The bench restarts a transfer partway through a packet, which exposes stale counters. It reads the data port before a packet is ready, which exposes a pointer that advances on an empty read. It writes the data port while a packet is being sent, which exposes a buffer overwritten mid-packet. It stalls the output stream irregularly, which exposes a byte that is dropped or changes before it is taken. Enable gating, clear-by-one and the interrupt mask are checked on the zero-length start, where a design that latches ungated events or ignores the mask would show a stray status bit or a stray interrupt.

// File: rtl/ppx_pkg.sv
`timescale 1ns/1ps
package ppx_pkg;
  localparam int EVT_W     = 8;
  localparam int EV_WR_RDY = 0;
  localparam int EV_RD_RDY = 1;
  localparam int EV_DONE   = 2;

  typedef enum logic [2:0] {
    ADR_CFG    = 3'd0,
    ADR_GO     = 3'd1,
    ADR_STS    = 3'd2,
    ADR_STS_EN = 3'd3,
    ADR_SIG_EN = 3'd4,
    ADR_DATA   = 3'd5
  } reg_addr_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FILL,
    ST_DRAIN,
    ST_LOAD,
    ST_SEND
  } seq_state_e;
endpackage

// File: rtl/ppx_buf.sv
`timescale 1ns/1ps
module ppx_buf #(
  parameter int SIZE_W = 11
) (
  input  logic              clk,
  input  logic              w_we,
  input  logic [SIZE_W-3:0] w_idx,
  input  logic [31:0]       w_wdata,
  output logic [31:0]       w_rdata,
  input  logic              b_we,
  input  logic [SIZE_W-1:0] b_idx,
  input  logic [7:0]        b_wdata,
  output logic [7:0]        b_rdata
);
  localparam int WORDS = 2 ** (SIZE_W - 2);
  localparam int LANES = 4;

  logic [SIZE_W-3:0] b_word;
  logic [7:0]        lane_rd [LANES];

  assign b_word = b_idx[SIZE_W-1:2];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_mem [WORDS];

    always_ff @(posedge clk) begin
      if (w_we) begin
        lane_mem[w_idx] <= w_wdata[8*l +: 8];
      end else if (b_we && (b_idx[1:0] == 2'(l))) begin
        lane_mem[b_word] <= b_wdata;
      end
    end

    assign w_rdata[8*l +: 8] = lane_mem[w_idx];
    assign lane_rd[l]        = lane_mem[b_word];
  end

  assign b_rdata = lane_rd[b_idx[1:0]];
endmodule

// File: rtl/ppx_evt.sv
`timescale 1ns/1ps
module ppx_evt #(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] ev_in,
  input  logic [EVT_W-1:0] sts_clr,
  input  logic             en_we,
  input  logic             sig_we,
  input  logic [EVT_W-1:0] wdata,
  output logic [EVT_W-1:0] sts,
  output logic [EVT_W-1:0] sts_en,
  output logic [EVT_W-1:0] sig_en,
  output logic             irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts    <= '0;
      sts_en <= '0;
      sig_en <= '0;
    end else begin
      sts <= (sts & ~sts_clr) | (ev_in & sts_en);
      if (en_we)  sts_en <= wdata;
      if (sig_we) sig_en <= wdata;
    end
  end

  assign irq = |(sts & sig_en);
endmodule

// File: rtl/ppx_seq.sv
`timescale 1ns/1ps
module ppx_seq
  import ppx_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int STEP_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_rd,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [STEP_W-1:0] cfg_steps,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic              host_rd,
  input  logic              host_wr,
  output logic              in_ready,
  output logic              out_valid,
  output logic              drain,
  output logic              w_we,
  output logic              b_we,
  output logic [SIZE_W-3:0] w_idx,
  output logic [SIZE_W-1:0] b_idx,
  output logic              ev_wr_rdy,
  output logic              ev_rd_rdy,
  output logic              ev_done
);
  localparam int WI_W = SIZE_W - 2;
  localparam logic [SIZE_W:0] ALIGN_MASK = {{(SIZE_W-1){1'b1}}, 2'b00};

  seq_state_e        state_q;
  logic [SIZE_W-1:0] size_q;
  logic [STEP_W-1:0] steps_q;
  logic [STEP_W-1:0] step_cnt;
  logic [SIZE_W-1:0] byte_cnt;
  logic [WI_W-1:0]   word_cnt;

  logic [SIZE_W:0]   ncyc;
  logic [SIZE_W-2:0] nwords;
  logic last_byte, last_word, last_step, go_zero;
  logic adv_fill, adv_drain, adv_load, adv_send, pkt_end_rd, pkt_end_wr;

  always_comb begin
    ncyc       = ({1'b0, size_q} + (SIZE_W+1)'(3)) & ALIGN_MASK;
    nwords     = ncyc[SIZE_W:2];
    last_byte  = ({1'b0, byte_cnt} == (ncyc - 1'b1));
    last_word  = ({1'b0, word_cnt} == (nwords - 1'b1));
    last_step  = (step_cnt == (steps_q - 1'b1));
    go_zero    = (cfg_size == '0) || (cfg_steps == '0);

    in_ready   = (state_q == ST_FILL);
    out_valid  = (state_q == ST_SEND);
    drain      = (state_q == ST_DRAIN);

    adv_fill   = in_ready && in_valid;
    adv_drain  = drain && host_rd;
    adv_load   = (state_q == ST_LOAD) && host_wr;
    adv_send   = out_valid && out_ready;
    pkt_end_rd = adv_drain && last_word;
    pkt_end_wr = adv_send && last_byte;

    b_we  = adv_fill && !go;
    w_we  = adv_load && !go;
    w_idx = word_cnt;
    b_idx = byte_cnt;

    if (go) begin
      ev_done   = go_zero;
      ev_rd_rdy = 1'b0;
      ev_wr_rdy = !go_zero && !go_rd;
    end else begin
      ev_done   = (pkt_end_rd || pkt_end_wr) && last_step;
      ev_rd_rdy = adv_fill && last_byte;
      ev_wr_rdy = pkt_end_wr && !last_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      size_q   <= '0;
      steps_q  <= '0;
      step_cnt <= '0;
      byte_cnt <= '0;
      word_cnt <= '0;
    end else if (go) begin
      size_q   <= cfg_size;
      steps_q  <= cfg_steps;
      step_cnt <= '0;
      byte_cnt <= '0;
      word_cnt <= '0;
      if (go_zero)    state_q <= ST_IDLE;
      else if (go_rd) state_q <= ST_FILL;
      else            state_q <= ST_LOAD;
    end else begin
      unique case (state_q)
        ST_FILL: if (adv_fill) begin
          if (last_byte) begin
            state_q  <= ST_DRAIN;
            word_cnt <= '0;
          end else begin
            byte_cnt <= byte_cnt + 1'b1;
          end
        end
        ST_DRAIN: if (adv_drain) begin
          if (!last_word) begin
            word_cnt <= word_cnt + 1'b1;
          end else if (last_step) begin
            state_q <= ST_IDLE;
          end else begin
            step_cnt <= step_cnt + 1'b1;
            byte_cnt <= '0;
            state_q  <= ST_FILL;
          end
        end
        ST_LOAD: if (adv_load) begin
          if (last_word) begin
            state_q  <= ST_SEND;
            byte_cnt <= '0;
          end else begin
            word_cnt <= word_cnt + 1'b1;
          end
        end
        ST_SEND: if (adv_send) begin
          if (!last_byte) begin
            byte_cnt <= byte_cnt + 1'b1;
          end else if (last_step) begin
            state_q <= ST_IDLE;
          end else begin
            step_cnt <= step_cnt + 1'b1;
            word_cnt <= '0;
            state_q  <= ST_LOAD;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ppx_xfer.sv
`timescale 1ns/1ps
module ppx_xfer
  import ppx_pkg::*;
#(
  parameter int SIZE_W = 11,
  parameter int STEP_W = 12
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        irq
);
  localparam int STEP_LSB = SIZE_W + 1;
  localparam int PAD_W    = 32 - STEP_LSB - STEP_W;

  logic [SIZE_W-1:0] cfg_size;
  logic [STEP_W-1:0] cfg_steps;
  logic              go, host_rd, host_wr, drain, w_we, b_we;
  logic [SIZE_W-3:0] w_idx;
  logic [SIZE_W-1:0] b_idx;
  logic [31:0]       w_rdata;
  logic              ev_wr_rdy, ev_rd_rdy, ev_done;
  logic [EVT_W-1:0]  ev_vec, sts_clr, sts, sts_en, sig_en;

  assign go      = reg_wr && (reg_addr == ADR_GO) && reg_wdata[0];
  assign host_rd = reg_rd && (reg_addr == ADR_DATA);
  assign host_wr = reg_wr && (reg_addr == ADR_DATA);
  assign sts_clr = (reg_wr && (reg_addr == ADR_STS)) ? reg_wdata[EVT_W-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_size  <= '0;
      cfg_steps <= '0;
    end else if (reg_wr && (reg_addr == ADR_CFG)) begin
      cfg_size  <= reg_wdata[SIZE_W-1:0];
      cfg_steps <= reg_wdata[STEP_LSB +: STEP_W];
    end
  end

  always_comb begin
    ev_vec            = '0;
    ev_vec[EV_WR_RDY] = ev_wr_rdy;
    ev_vec[EV_RD_RDY] = ev_rd_rdy;
    ev_vec[EV_DONE]   = ev_done;
  end

  ppx_seq #(.SIZE_W(SIZE_W), .STEP_W(STEP_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .go_rd(reg_wdata[1]),
    .cfg_size(cfg_size), .cfg_steps(cfg_steps),
    .in_valid(in_valid), .out_ready(out_ready),
    .host_rd(host_rd), .host_wr(host_wr),
    .in_ready(in_ready), .out_valid(out_valid), .drain(drain),
    .w_we(w_we), .b_we(b_we), .w_idx(w_idx), .b_idx(b_idx),
    .ev_wr_rdy(ev_wr_rdy), .ev_rd_rdy(ev_rd_rdy), .ev_done(ev_done)
  );

  ppx_buf #(.SIZE_W(SIZE_W)) u_buf (
    .clk(clk), .w_we(w_we), .w_idx(w_idx), .w_wdata(reg_wdata), .w_rdata(w_rdata),
    .b_we(b_we), .b_idx(b_idx), .b_wdata(in_data), .b_rdata(out_data)
  );

  ppx_evt #(.EVT_W(EVT_W)) u_evt (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_vec), .sts_clr(sts_clr),
    .en_we(reg_wr && (reg_addr == ADR_STS_EN)),
    .sig_we(reg_wr && (reg_addr == ADR_SIG_EN)),
    .wdata(reg_wdata[EVT_W-1:0]),
    .sts(sts), .sts_en(sts_en), .sig_en(sig_en), .irq(irq)
  );

  always_comb begin
    unique case (reg_addr)
      ADR_CFG:    reg_rdata = {{PAD_W{1'b0}}, cfg_steps, 1'b0, cfg_size};
      ADR_STS:    reg_rdata = {{(32-EVT_W){1'b0}}, sts};
      ADR_STS_EN: reg_rdata = {{(32-EVT_W){1'b0}}, sts_en};
      ADR_SIG_EN: reg_rdata = {{(32-EVT_W){1'b0}}, sig_en};
      ADR_DATA:   reg_rdata = drain ? w_rdata : 32'd0;
      default:    reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/ppx_chk.sv
`timescale 1ns/1ps
module ppx_chk
  import ppx_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             reg_wr,
  input logic [2:0]       reg_addr,
  input logic [31:0]      reg_wdata,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [7:0]       out_data,
  input logic             irq,
  input logic [EVT_W-1:0] sts,
  input logic [EVT_W-1:0] sts_en,
  input logic [EVT_W-1:0] sig_en,
  input logic [EVT_W-1:0] ev_vec
);
  // R12
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R2
  one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R11
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sig_en == '0) |-> !irq);

  // R8
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_vec[EV_DONE] |-> !ev_vec[EV_RD_RDY]);

  for (genvar k = 0; k < EVT_W; k++) begin : g_bit
    // R10
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sts[k] && !sts_en[k]) |=> !sts[k]);
    // R10
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == ADR_STS) && reg_wdata[k] && !ev_vec[k]) |=> !sts[k]);
  end
endmodule

bind ppx_xfer ppx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .irq(irq),
  .sts(sts), .sts_en(sts_en), .sig_en(sig_en), .ev_vec(ev_vec)
);

// File: tb/test_ppx_xfer.sv
`timescale 1ns/1ps
module test_ppx_xfer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        in_valid = 1'b0, in_ready;
  logic [7:0]  in_data = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [7:0]  out_data;
  logic        irq;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  ppx_xfer i_ppx_xfer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .irq(irq)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk);
    #1 reg_rd = 1'b0;
  endtask

  function automatic logic [7:0] pat(int seed, int s, int k);
    return 8'(seed * 29 + s * 37 + k * 5 + 3);
  endfunction

  function automatic logic [31:0] pword(int seed, int s, int w);
    return {pat(seed, s, 4*w+3), pat(seed, s, 4*w+2), pat(seed, s, 4*w+1), pat(seed, s, 4*w)};
  endfunction

  task automatic feed(input int seed, input int s, input int k0, input int k1);
    int k = k0;
    int g = 0;
    logic acc;
    while (k < k1 && g < 20000) begin
      @(negedge clk);
      in_valid = ((g % 3) != 2);
      in_data  = pat(seed, s, k);
      #1 acc = in_valid && in_ready;
      @(posedge clk);
      if (acc) k++;
      g++;
    end
    #1 in_valid = 1'b0;
    if (k != k1) chk("R4", "bytes accepted", k, k1);
  endtask

  task automatic run_read(input int size, input int steps, input int seed);
    int ncyc = (size + 3) / 4 * 4;
    int nw   = ncyc / 4;
    logic [31:0] d;
    wr(3'd0, 32'(steps << 12 | size));
    wr(3'd2, 32'hFF);
    wr(3'd1, 32'h3);
    for (int s = 0; s < steps; s++) begin
      feed(seed, s, 0, ncyc);
      @(negedge clk); in_valid = 1'b1; #1;
      chk("R6", "in_ready after full packet", in_ready, 0);
      in_valid = 1'b0;
      rd(3'd2, d);
      chk("R6", "read-ready bit1", d[1], 1);
      chk("R8", "no early complete", d[2], 0);
      wr(3'd2, 32'h2);
      for (int w = 0; w < nw; w++) begin
        rd(3'd5, d);
        chk("R5", $sformatf("word %0d size %0d step %0d", w, size, s), d, pword(seed, s, w));
      end
    end
    rd(3'd2, d);
    chk("R8", "complete after last read", d[2], 1);
    chk("R6", "no read-ready after drain", d[1], 0);
    rd(3'd5, d);
    chk("R9", "empty data read", d, 0);
  endtask

  task automatic run_write(input int size, input int steps, input int seed);
    int ncyc = (size + 3) / 4 * 4;
    int nw   = ncyc / 4;
    logic [31:0] d;
    wr(3'd0, 32'(steps << 12 | size));
    wr(3'd2, 32'hFF);
    wr(3'd1, 32'h1);
    for (int s = 0; s < steps; s++) begin
      int k = 0;
      int g = 0;
      logic v, held;
      logic [7:0] dt, held_d;
      rd(3'd2, d);
      chk("R7", "write-ready bit0", d[0], 1);
      chk("R8", "no early complete", d[2], 0);
      wr(3'd2, 32'h1);
      for (int w = 0; w < nw; w++) wr(3'd5, pword(seed, s, w));
      wr(3'd5, 32'hDEADBEEF);
      held = 1'b0; held_d = '0;
      while (k < ncyc && g < 20000) begin
        @(negedge clk);
        out_ready = ((g % 4) != 1);
        #1 v = out_valid; dt = out_data;
        if (held) begin
          chk("R12", "valid held", v, 1);
          chk("R12", "data held", dt, held_d);
        end
        if (v && out_ready) begin
          chk("R5", $sformatf("byte %0d size %0d step %0d", k, size, s), dt, pat(seed, s, k));
          k++;
        end
        held = v && !out_ready; held_d = dt;
        @(posedge clk);
        g++;
      end
      #1 out_ready = 1'b0;
      @(negedge clk); #1;
      chk("R4", "no byte after packet", out_valid, 0);
    end
    rd(3'd2, d);
    chk("R8", "complete after last byte", d[2], 1);
    chk("R7", "no write-ready after last", d[0], 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    rd(3'd0, d); chk("R1", "cfg reset", d, 0);
    rd(3'd2, d); chk("R1", "status reset", d, 0);
    rd(3'd3, d); chk("R1", "status enable reset", d, 0);
    rd(3'd4, d); chk("R1", "irq enable reset", d, 0);
    chk("R11", "irq reset", irq, 0);
    chk("R2", "in_ready idle", in_ready, 0);
    chk("R2", "out_valid idle", out_valid, 0);

    wr(3'd0, 32'hFFFFFFFF);
    rd(3'd0, d); chk("R1", "cfg field mask", d, 32'h00FFF7FF);
    wr(3'd0, 32'h00ABC123);
    rd(3'd0, d); chk("R1", "cfg fields", d, 32'h00ABC123);

    rd(3'd5, d); chk("R9", "idle data read", d, 0);

    // R10 gating: disabled events are not latched
    wr(3'd0, 32'h00003000);
    wr(3'd1, 32'h1);
    rd(3'd2, d); chk("R10", "ungated event", d, 0);

    wr(3'd3, 32'h07);
    // R3 zero size
    wr(3'd0, 32'h00003000);
    wr(3'd1, 32'h3);
    rd(3'd2, d); chk("R3", "zero size complete", d, 32'h4);
    chk("R3", "zero size no fill", in_ready, 0);
    wr(3'd2, 32'h3);
    rd(3'd2, d); chk("R10", "clear other bits keeps bit2", d, 32'h4);
    wr(3'd2, 32'h4);
    rd(3'd2, d); chk("R10", "write one clears", d, 0);
    // R3 zero steps
    wr(3'd0, 32'h00000005);
    wr(3'd1, 32'h1);
    rd(3'd2, d); chk("R3", "zero steps complete", d, 32'h4);
    chk("R3", "zero steps no send", out_valid, 0);

    // R11 interrupt mask
    wr(3'd4, 32'h01);
    #1 chk("R11", "masked irq", irq, 0);
    wr(3'd4, 32'h04);
    #1 chk("R11", "enabled irq", irq, 1);
    wr(3'd2, 32'h4);
    #1 chk("R11", "irq after clear", irq, 0);
    wr(3'd4, 32'h00);

    // R9 and R7: empty read mid-fill, ignored data write in read direction
    wr(3'd0, 32'h00001008);
    wr(3'd1, 32'h3);
    feed(5, 0, 0, 3);
    rd(3'd5, d); chk("R9", "read during fill", d, 0);
    wr(3'd5, 32'h12345678);
    feed(5, 0, 3, 8);
    rd(3'd5, d); chk("R9", "word0 not advanced", d, pword(5, 0, 0));
    rd(3'd5, d); chk("R7", "word1 not overwritten", d, pword(5, 0, 1));

    // R2 restart mid-packet
    wr(3'd0, 32'h00001008);
    wr(3'd1, 32'h3);
    feed(99, 0, 0, 3);
    run_read(8, 1, 7);

    for (int size = 1; size <= 9; size++)
      for (int steps = 1; steps <= 3; steps++) begin
        run_read(size, steps, size + steps);
        run_write(size, steps, size * 3 + steps);
      end

    run_read(2047, 2, 11);
    run_write(2047, 2, 13);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule